// File: doc/BRIEF.md
# Ray Traversal Pointer Stack

This block keeps the list of pending node pointers for one ray while it walks a bounding volume hierarchy. After a wide box node has been tested, the children that the ray hit arrive already sorted nearest first, as up to eight 32-bit pointers with a lane mask. In the same operation the block pushes those children and hands back the next work. That is either one pointer, for single-path traversal, or two pointers packed into one 64-bit word, so that two paths can advance side by side.

The entries sit in a small local RAM that works as a circular buffer. When a push would go past the capacity, the oldest entries are overwritten in place and a sticky flag records the loss. When fewer entries exist than the pop asks for, the missing result slots are marked invalid and an empty indication is raised. A response appears on the cycle after each operation.

Top module: `trav_stack`

## Requirements
- R1: After synchronous reset the stack holds no entries, the overflow flag is low and no response is valid.
- R2: An operation pushes exactly the lanes whose mask bit is set, so the push count is the popcount of the mask. Pointer values on lanes whose mask bit is clear are never stored or returned.
- R3: Set lanes are stored so that the lowest set lane index ends on top. Successive pops therefore return the pushed children in ascending lane order, and entries from earlier operations follow in last-in first-out order.
- R4: Within one operation the push is applied before the pop, so a child pushed by that operation can be returned by it.
- R5: With the pop kind at 0 (single pop), the top entry is returned in bits 31:0 of the result with valid bit 0. Valid bit 1 is low and bits 63:32 are zero.
- R6: With the pop kind at 1 (double pop), bits 31:0 carry the top entry and bits 63:32 carry the entry directly below it. Valid bit 1 is never set without valid bit 0.
- R7: When the stack, after the push, holds fewer entries than the pop asks for, the missing slots have their valid bit low and zero data, the empty output is high, and the stack is left empty. Otherwise the empty output is low.
- R8: The stack holds DEPTH entries (16 by default). A push beyond that drops the oldest entries and sets an overflow flag. The flag stays high until reset.
- R9: The response is valid exactly one cycle after an operation is presented. A cycle without an operation produces no response and leaves the stack contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_pop_two | input | 1 | Pop kind: 0 pops one entry, 1 pops two |
| push_mask | input | LANES (8) | Lanes to push; bit i selects lane i |
| push_ptrs | input | LANES*PTR_W (256) | Child pointers; lane i in bits i*32 +: 32, nearest child in lane 0 |
| rsp_valid | output | 1 | Response of the previous cycle's operation |
| rsp_pair | output | 2*PTR_W (64) | Popped pointers: top in low half, next in high half |
| rsp_vld | output | 2 | Per-slot valid bits for the two halves of rsp_pair |
| rsp_empty | output | 1 | Fewer entries were available than requested |
| ovf_sticky | output | 1 | Sticky flag that entries were dropped on overflow |

## Verification
The assertions assume that op_pop_two and push_mask carry defined values whenever op_valid is high. They also assume that the block's parameters keep DEPTH a power of two no smaller than LANES and no smaller than four. The bench keeps to this by holding every input at a known level from time zero and by driving inputs only on the falling edge. It uses only the default eight-lane, sixteen-entry configuration. The stimulus sweeps all 256 masks with both pop kinds and drains the stack after each one. Lanes whose mask bit is clear always carry distinctive junk values, so any leak into the stack shows up in the popped data.

// File: rtl/tstk_pkg.sv
package tstk_pkg;

    typedef enum logic {
        POP_ONE = 1'b0,
        POP_TWO = 1'b1
    } pop_kind_e;

    typedef struct packed {
        logic hit0;     // top slot delivered
        logic hit1;     // second slot delivered
        logic short_f;  // request exceeded available entries
    } pop_flags_t;

    function automatic int unsigned want_of(pop_kind_e k);
        return (k == POP_TWO) ? 2 : 1;
    endfunction

endpackage

// File: rtl/tstk_place.sv
module tstk_place #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned RANK_W = 3
) (
    input  logic [LANES-1:0]  mask,
    output logic [RANK_W-1:0] rank [LANES],
    output logic [CNT_W-1:0]  n_push
);
    // rank of lane i = number of set lanes above it; highest set lane goes
    // in first, lane 0 last, so the nearest child ends on top
    for (genvar i = 0; i < LANES; i++) begin : g_rank
        always_comb begin
            rank[i] = '0;
            for (int j = i + 1; j < LANES; j++) begin
                rank[i] = rank[i] + RANK_W'(mask[j]);
            end
        end
    end

    always_comb begin
        n_push = '0;
        for (int k = 0; k < LANES; k++) begin
            n_push = n_push + CNT_W'(mask[k]);
        end
    end
endmodule

// File: rtl/tstk_store.sv
module tstk_store #(
    parameter int unsigned PTR_W  = 32,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned LANES  = 8,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned RANK_W = 3
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [LANES-1:0]       mask,
    input  logic [LANES*PTR_W-1:0] ptrs,
    input  logic [RANK_W-1:0]      rank [LANES],
    input  logic [IDX_W-1:0]       head,
    input  logic [IDX_W-1:0]       rd_idx0,
    input  logic [IDX_W-1:0]       rd_idx1,
    output logic [PTR_W-1:0]       rd_data0,
    output logic [PTR_W-1:0]       rd_data1
);
    logic [PTR_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] mem_n [DEPTH];
    logic [IDX_W-1:0] slot  [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_slot
        assign slot[i] = head + IDX_W'(rank[i]);
    end

    // post-push view; reads come from it so a fresh push is visible at once
    always_comb begin
        for (int d = 0; d < DEPTH; d++) begin
            mem_n[d] = mem_q[d];
            for (int i = 0; i < LANES; i++) begin
                if (we && mask[i] && (slot[i] == IDX_W'(d))) begin
                    mem_n[d] = ptrs[i*PTR_W +: PTR_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int d = 0; d < DEPTH; d++) begin
            mem_q[d] <= mem_n[d];
        end
    end

    assign rd_data0 = mem_n[rd_idx0];
    assign rd_data1 = mem_n[rd_idx1];
endmodule

// File: rtl/tstk_ctrl.sv
module tstk_ctrl
    import tstk_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 8,
    parameter int unsigned CNT_W = 5,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  pop_kind_e        kind,
    input  logic [CNT_W-1:0] n_push,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] rd_idx0,
    output logic [IDX_W-1:0] rd_idx1,
    output pop_flags_t       flags,
    output logic             ovf_sticky
);
    logic [CNT_W-1:0] count_q, count_n, avail;
    logic [IDX_W-1:0] head_q, head_n, head_push;
    logic [CNT_W:0]   sum;
    logic             ovf_now, ovf_q;
    logic [1:0]       got;

    always_comb begin
        sum       = {1'b0, count_q} + {1'b0, n_push};
        ovf_now   = sum > (CNT_W+1)'(DEPTH);
        avail     = ovf_now ? CNT_W'(DEPTH) : sum[CNT_W-1:0];
        head_push = head_q + IDX_W'(n_push);
        rd_idx0   = head_push - IDX_W'(1);
        rd_idx1   = head_push - IDX_W'(2);

        flags.hit0    = (avail != '0);
        flags.hit1    = (kind == POP_TWO) && (avail >= CNT_W'(2));
        flags.short_f = avail < CNT_W'(want_of(kind));

        got     = 2'(flags.hit0) + 2'(flags.hit1);
        count_n = avail - CNT_W'(got);
        head_n  = head_push - IDX_W'(got);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            head_q  <= '0;
            ovf_q   <= 1'b0;
        end else if (op_valid) begin
            count_q <= count_n;
            head_q  <= head_n;
            if (ovf_now) ovf_q <= 1'b1;
        end
    end

    assign head_o     = head_q;
    assign ovf_sticky = ovf_q;

    p_count_cap_r8: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(count_q) && $stable(head_q)));
endmodule

// File: rtl/trav_stack.sv
module trav_stack
    import tstk_pkg::*;
#(
    parameter int unsigned PTR_W = 32,
    parameter int unsigned LANES = 8,
    parameter int unsigned DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_valid,
    input  logic                   op_pop_two,
    input  logic [LANES-1:0]       push_mask,
    input  logic [LANES*PTR_W-1:0] push_ptrs,
    output logic                   rsp_valid,
    output logic [2*PTR_W-1:0]     rsp_pair,
    output logic [1:0]             rsp_vld,
    output logic                   rsp_empty,
    output logic                   ovf_sticky
);
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned RANK_W = $clog2(LANES);

    pop_kind_e        kind;
    logic [RANK_W-1:0] rank [LANES];
    logic [CNT_W-1:0] n_push;
    logic [IDX_W-1:0] head, rd_idx0, rd_idx1;
    logic [PTR_W-1:0] rd_data0, rd_data1;
    pop_flags_t       flags;

    logic               vq;
    logic [2*PTR_W-1:0] pair_q;
    logic [1:0]         vld_q;
    logic               empty_q;

    assign kind = op_pop_two ? POP_TWO : POP_ONE;

    tstk_place #(.LANES(LANES), .CNT_W(CNT_W), .RANK_W(RANK_W)) u_place (
        .mask   (push_mask),
        .rank   (rank),
        .n_push (n_push)
    );

    tstk_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .kind       (kind),
        .n_push     (n_push),
        .head_o     (head),
        .rd_idx0    (rd_idx0),
        .rd_idx1    (rd_idx1),
        .flags      (flags),
        .ovf_sticky (ovf_sticky)
    );

    tstk_store #(.PTR_W(PTR_W), .DEPTH(DEPTH), .LANES(LANES),
                 .IDX_W(IDX_W), .RANK_W(RANK_W)) u_store (
        .clk      (clk),
        .we       (op_valid),
        .mask     (push_mask),
        .ptrs     (push_ptrs),
        .rank     (rank),
        .head     (head),
        .rd_idx0  (rd_idx0),
        .rd_idx1  (rd_idx1),
        .rd_data0 (rd_data0),
        .rd_data1 (rd_data1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vq      <= 1'b0;
            pair_q  <= '0;
            vld_q   <= '0;
            empty_q <= 1'b0;
        end else begin
            vq <= op_valid;
            if (op_valid) begin
                pair_q  <= {flags.hit1 ? rd_data1 : '0, flags.hit0 ? rd_data0 : '0};
                vld_q   <= {flags.hit1, flags.hit0};
                empty_q <= flags.short_f;
            end
        end
    end

    assign rsp_valid = vq;
    assign rsp_pair  = pair_q;
    assign rsp_vld   = vld_q;
    assign rsp_empty = empty_q;

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> rsp_valid);

    p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !rsp_valid);

    p_single_hi_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_pop_two) |=> (!rsp_vld[1] && rsp_pair[2*PTR_W-1:PTR_W] == '0));

    p_slot_order_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_vld[1] |-> rsp_vld[0]);

    p_full_when_not_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_pop_two) |=> (rsp_empty || rsp_vld == 2'b11));

    p_empty_marks_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_empty) |-> !rsp_vld[1]);
endmodule

// File: tb/tb_trav_stack.sv
module tb_trav_stack;
    localparam int PTR_W = 32;
    localparam int LANES = 8;
    localparam int DEPTH = 16;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   op_valid = 1'b0;
    logic                   op_pop_two = 1'b0;
    logic [LANES-1:0]       push_mask = '0;
    logic [LANES*PTR_W-1:0] push_ptrs = '0;
    logic                   rsp_valid;
    logic [2*PTR_W-1:0]     rsp_pair;
    logic [1:0]             rsp_vld;
    logic                   rsp_empty;
    logic                   ovf_sticky;

    int nvec = 0;
    int nerr = 0;
    int seq  = 0;

    logic [31:0] mstk [DEPTH];
    int          mcnt = 0;
    logic        movf = 1'b0;

    always #2 clk = ~clk;

    trav_stack #(.PTR_W(PTR_W), .LANES(LANES), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_pop_two(op_pop_two),
        .push_mask(push_mask), .push_ptrs(push_ptrs), .rsp_valid(rsp_valid),
        .rsp_pair(rsp_pair), .rsp_vld(rsp_vld), .rsp_empty(rsp_empty),
        .ovf_sticky(ovf_sticky)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mpush(input logic [31:0] v);
        if (mcnt == DEPTH) begin
            for (int k = 0; k < DEPTH - 1; k++) mstk[k] = mstk[k+1];
            mcnt--;
            movf = 1'b1;
        end
        mstk[mcnt] = v;
        mcnt++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mcnt = 0; movf = 1'b0;
        chk(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
        chk(ovf_sticky == 1'b0, "R1", 64'(ovf_sticky), 64'd0);
    endtask

    task automatic run_op(input logic [7:0] mask, input logic two, input string dtag);
        logic [63:0] ep;
        logic [1:0]  ev;
        logic        ee;
        seq++;
        @(negedge clk);
        op_valid = 1'b1; op_pop_two = two; push_mask = mask;
        for (int i = 0; i < LANES; i++)
            push_ptrs[i*PTR_W +: PTR_W] = mask[i] ? 32'(seq*16 + i + 1) : (32'hDEAD0000 | 32'(i));
        for (int i = LANES - 1; i >= 0; i--)
            if (mask[i]) mpush(32'(seq*16 + i + 1));
        ep = '0; ev = '0;
        ee = (mcnt < (two ? 2 : 1));
        if (mcnt > 0) begin mcnt--; ep[31:0] = mstk[mcnt]; ev[0] = 1'b1; end
        if (two && mcnt > 0) begin mcnt--; ep[63:32] = mstk[mcnt]; ev[1] = 1'b1; end
        @(negedge clk);
        op_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R9", 64'(rsp_valid), 64'd1);
        chk(rsp_pair == ep, dtag, rsp_pair, ep);
        chk(rsp_vld == ev, two ? "R6" : "R5", 64'(rsp_vld), 64'(ev));
        chk(rsp_empty == ee, "R7", 64'(rsp_empty), 64'(ee));
        chk(ovf_sticky == movf, "R8", 64'(ovf_sticky), 64'(movf));
    endtask

    task automatic idle_chk();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        fork
            begin
                do_reset();
                // R1: fresh stack is empty
                run_op(8'h00, 1'b0, "R1");
                idle_chk();
                // R4: children pushed this op are popped by it
                run_op(8'b0000_0101, 1'b1, "R4");
                // R3: ordering across two pushes
                run_op(8'b1100_0000, 1'b0, "R3");
                run_op(8'b0000_0011, 1'b0, "R3");
                while (mcnt > 0) run_op(8'h00, 1'b1, "R3");
                // R2/R3: sweep of every mask, both pop kinds, drained each time
                for (int p = 0; p < 2; p++) begin
                    for (int m = 0; m < 256; m++) begin
                        run_op(8'(m), 1'(p), (m == 0) ? "R7" : "R2");
                        while (mcnt > 0) run_op(8'h00, 1'(m & 1), "R3");
                        run_op(8'h00, 1'b1, "R7");
                    end
                end
                idle_chk();
                // R8: overflow drops oldest and sticks
                run_op(8'hFF, 1'b0, "R8");
                run_op(8'hFF, 1'b0, "R8");
                run_op(8'hFF, 1'b0, "R8");
                idle_chk();
                while (mcnt > 0) run_op(8'h00, 1'b1, "R8");
                run_op(8'h00, 1'b0, "R8");
                // R1: reset clears the sticky flag
                do_reset();
                run_op(8'h00, 1'b1, "R1");
                // mixed traffic without draining
                for (int m = 0; m < 256; m++) begin
                    run_op(8'(m * 37), 1'(m[1] ^ m[4]), "R3");
                    if (m % 5 == 0) run_op(8'h00, 1'b1, "R6");
                end
                while (mcnt > 0) run_op(8'h00, 1'b1, "R3");
            end
            begin
                repeat (150000) @(posedge clk);
                nvec++; nerr++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule